// File: doc/BRIEF.md
# Auto-Request DMA Channel with Bus Modes

This block is a single dual-address DMA channel. Each transfer unit reads one byte or one 16-bit word from a 24-bit source address and writes it to a 24-bit destination address. Both accesses go over a valid/ready master port. Before it touches the master port, the channel asks a bus arbiter for the bus with a request/grant pair. Software sets the channel up through a small write-only register port. The last write goes to the control register with the enable bit set.

The channel has two trigger modes. In auto-request mode it starts as soon as it is enabled and runs until the programmed count is used up. In this mode a mode bit chooses how the bus is used:
- **Cycle-steal:** the bus is handed back after every unit.
- **Burst:** the bus is held until the last unit is done.

In external mode, each rising edge of `ext_req` moves exactly one unit. When the whole count has been moved, a level interrupt is raised. Any later write to the control register clears it.

Register select codes on `cfg_sel` are:
- 0: source address
- 1: destination address
- 2: transfer count
- 3: control

Control bits are:
- bit 0: enable
- bit 1: auto-request (0 = external)
- bit 2: burst (0 = cycle-steal)
- bit 3: word unit (0 = byte)

Top module: `dma_autoreq_chan`

## Requirements
- R1: Each unit is one read at the full 24-bit current source address (`m_write`=0), followed by one write at the full 24-bit current destination address (`m_write`=1). The write carries the data returned by that read.
- R2: A control write with bit 0 and bit 1 set starts the channel with no external request. It then moves exactly the programmed count of units.
- R3: In cycle-steal mode (control bit 2 = 0), `bus_req` goes low for at least one clock after every unit. The next unit waits for a new grant.
- R4: In auto-request burst mode (bit 1 and bit 2 set), `bus_req` stays high from the first grant until the last unit has been written.
- R5: In external mode (bit 1 = 0), one unit is moved per rising edge of `ext_req`. Without an edge nothing is moved, and a held-high level does not trigger again.
- R6: After each unit both addresses advance by 1 when control bit 3 = 0 (byte), and by 2 when bit 3 = 1 (word).
- R7: `irq` rises after the final unit of the count. Any control-register write clears it.
- R8: A control write with bit 0 clear during a transfer lets the current unit finish. The channel then drops `bus_req` and stops, without raising `irq`.
- R9: A programmed count of 0 means 65536 units.
- R10: `m_valid` is high only while `bus_req` and `bus_gnt` are both high. While `m_valid` is high and `m_ready` is low, the address and direction hold steady.
- R11: While the channel is busy, writes to the source, destination and count registers, and to the mode bits, are ignored.
- R12: After reset, `bus_req`, `m_valid` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 src, 1 dst, 2 count, 3 control) |
| cfg_wdata | input | 24 | Register write data |
| ext_req | input | 1 | External transfer request, rising-edge sensitive |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| m_valid | output | 1 | Master access valid |
| m_ready | input | 1 | Master access accepted |
| m_write | output | 1 | 1 = write, 0 = read |
| m_word | output | 1 | 1 = 16-bit access, 0 = byte access |
| m_addr | output | 24 | Access address |
| m_wdata | output | 16 | Write data |
| m_rdata | input | 16 | Read data, valid in the read handshake cycle |
| irq | output | 1 | Transfer-complete interrupt, level |

## Verification
The assertions assume two things about the arbiter:
- It raises `bus_gnt` only in answer to `bus_req`.
- It keeps the grant until `bus_req` falls.

They also assume that `m_rdata` is valid in the cycle `m_ready` accepts a read. The bench arbiter follows the channel's request half a clock later and drops the grant as soon as the request falls. The bench memory returns data computed from the address, so every write can be checked against the source it came from. The bench drives `m_ready` either constantly high or from a pseudo-random pattern, which exercises back-pressure in both the read and the write phase.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_ARB,
    ST_RD,
    ST_WR,
    ST_REL
  } dma_state_e;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  localparam int CB_EN    = 0;
  localparam int CB_AUTO  = 1;
  localparam int CB_BURST = 2;
  localparam int CB_WORD  = 3;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          busy,
  input  logic          fin,
  output logic [AW-1:0] src_cfg,
  output logic [AW-1:0] dst_cfg,
  output logic [CW-1:0] cnt_cfg,
  output logic          mode_auto,
  output logic          mode_burst,
  output logic          mode_word,
  output logic          en,
  output logic          start,
  output logic          ctrl_wr
);
  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
  assign start   = ctrl_wr && wr_data[CB_EN] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_cfg    <= '0;
      dst_cfg    <= '0;
      cnt_cfg    <= '0;
      mode_auto  <= 1'b0;
      mode_burst <= 1'b0;
      mode_word  <= 1'b0;
      en         <= 1'b0;
    end else begin
      if (wr_en && !busy) begin
        case (wr_sel)
          SEL_SRC: src_cfg <= wr_data;
          SEL_DST: dst_cfg <= wr_data;
          SEL_CNT: cnt_cfg <= wr_data[CW-1:0];
          default: ;
        endcase
      end
      if (start) begin
        mode_auto  <= wr_data[CB_AUTO];
        mode_burst <= wr_data[CB_BURST];
        mode_word  <= wr_data[CB_WORD];
      end
      if (start)                            en <= 1'b1;
      else if (ctrl_wr && !wr_data[CB_EN])  en <= 1'b0;
      else if (fin)                         en <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          word,
  input  logic [AW-1:0] src_init,
  input  logic [AW-1:0] dst_init,
  input  logic [CW-1:0] cnt_init,
  output logic [AW-1:0] src_cur,
  output logic [AW-1:0] dst_cur,
  output logic          last
);
  localparam int NPTR = 2;
  localparam logic [CW:0] ONE  = {{CW{1'b0}}, 1'b1};
  localparam logic [CW:0] FULL = {1'b1, {CW{1'b0}}};

  logic [AW-1:0] inc;
  logic [AW-1:0] init_a [NPTR];
  logic [AW-1:0] cur_a  [NPTR];
  logic [CW:0]   left_q;

  assign inc       = {{(AW-2){1'b0}}, word, ~word};
  assign init_a[0] = src_init;
  assign init_a[1] = dst_init;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic [AW-1:0] ptr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr_q <= '0;
      else if (load)  ptr_q <= init_a[g];
      else if (step)  ptr_q <= ptr_q + inc;
    end
    assign cur_a[g] = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     left_q <= '0;
    else if (load)  left_q <= (cnt_init == '0) ? FULL : {1'b0, cnt_init};
    else if (step)  left_q <= left_q - ONE;
  end

  assign src_cur = cur_a[0];
  assign dst_cur = cur_a[1];
  assign last    = (left_q == ONE);
endmodule

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       en,
  input  logic       mode_auto,
  input  logic       mode_burst,
  input  logic       ext_req,
  input  logic       bus_gnt,
  input  logic       m_ready,
  input  logic       last,
  input  logic       ctrl_wr,
  output dma_state_e state_o,
  output logic       bus_req,
  output logic       m_valid,
  output logic       m_write,
  output logic       step,
  output logic       capture,
  output logic       fin,
  output logic       irq
);
  dma_state_e st_q, st_d;
  logic req_q, pend_q, req_edge, consume;

  assign req_edge = ext_req && !req_q;
  assign consume  = (st_q == ST_ARMED) && en && !mode_auto && pend_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = ST_ARMED;
      ST_ARMED: if (!en) st_d = ST_IDLE;
                else if (mode_auto || pend_q) st_d = ST_ARB;
      ST_ARB:   if (!en) st_d = ST_IDLE;
                else if (bus_gnt) st_d = ST_RD;
      ST_RD:    if (m_ready) st_d = ST_WR;
      ST_WR:    if (m_ready) begin
                  if (last || !en)                st_d = ST_IDLE;
                  else if (mode_auto && mode_burst) st_d = ST_RD;
                  else                            st_d = ST_REL;
                end
      ST_REL:   st_d = ST_ARMED;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      req_q  <= 1'b0;
      pend_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      st_q  <= st_d;
      req_q <= ext_req;
      if (start)                               pend_q <= 1'b0;
      else if (req_edge && st_q != ST_IDLE)    pend_q <= 1'b1;
      else if (consume)                        pend_q <= 1'b0;
      if (fin && en)     irq <= 1'b1;
      else if (ctrl_wr)  irq <= 1'b0;
    end
  end

  assign state_o = st_q;
  assign m_valid = (st_q == ST_RD) || (st_q == ST_WR);
  assign m_write = (st_q == ST_WR);
  assign bus_req = (st_q == ST_ARB) || m_valid;
  assign step    = m_write && m_ready;
  assign capture = (st_q == ST_RD) && m_ready;
  assign fin     = step && last;
endmodule

// File: rtl/dma_autoreq_chan.sv
module dma_autoreq_chan
  import dma_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          ext_req,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          m_valid,
  input  logic          m_ready,
  output logic          m_write,
  output logic          m_word,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata,
  output logic          irq
);
  logic [AW-1:0] src_cfg, dst_cfg, src_cur, dst_cur;
  logic [CW-1:0] cnt_cfg;
  logic mode_auto, mode_burst, mode_word, chan_en;
  logic start, ctrl_wr, fin, step, capture, last_unit, busy;
  dma_state_e state;
  logic [DW-1:0] hold_q;

  assign busy = (state != ST_IDLE);

  dma_cfg_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_sel),
    .wr_data(cfg_wdata), .busy(busy), .fin(fin),
    .src_cfg(src_cfg), .dst_cfg(dst_cfg), .cnt_cfg(cnt_cfg),
    .mode_auto(mode_auto), .mode_burst(mode_burst), .mode_word(mode_word),
    .en(chan_en), .start(start), .ctrl_wr(ctrl_wr)
  );

  dma_addr_unit #(.AW(AW), .CW(CW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(start), .step(step), .word(mode_word),
    .src_init(src_cfg), .dst_init(dst_cfg), .cnt_init(cnt_cfg),
    .src_cur(src_cur), .dst_cur(dst_cur), .last(last_unit)
  );

  dma_bus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .en(chan_en),
    .mode_auto(mode_auto), .mode_burst(mode_burst), .ext_req(ext_req),
    .bus_gnt(bus_gnt), .m_ready(m_ready), .last(last_unit), .ctrl_wr(ctrl_wr),
    .state_o(state), .bus_req(bus_req), .m_valid(m_valid), .m_write(m_write),
    .step(step), .capture(capture), .fin(fin), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (capture) hold_q <= m_rdata;
  end

  assign m_addr  = m_write ? dst_cur : src_cur;
  assign m_wdata = hold_q;
  assign m_word  = mode_word;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          m_valid,
  input logic          m_ready,
  input logic          m_write,
  input logic [AW-1:0] m_addr,
  input logic          irq,
  input logic          mode_auto,
  input logic          mode_burst,
  input logic          last_unit,
  input logic          chan_en
);
  // R10
  valid_has_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (bus_req && bus_gnt));

  // R10
  hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)));

  // R3
  steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_write && !(mode_auto && mode_burst)) |=> !bus_req);

  // R4
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_write && mode_auto && mode_burst && !last_unit && chan_en)
      |=> (bus_req && m_valid && !m_write));

  // R7
  irq_after_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(m_valid && m_ready && m_write));

  // R1
  read_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_write && !$past(m_write)) |-> $past(m_valid && m_ready && !m_write));
endmodule

bind dma_autoreq_chan dma_chan_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write), .m_addr(m_addr),
  .irq(irq), .mode_auto(mode_auto), .mode_burst(mode_burst),
  .last_unit(last_unit), .chan_en(chan_en)
);

// File: tb/sim_dma_autoreq_chan.sv
`timescale 1ns/1ps
module sim_dma_autoreq_chan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [23:0] cfg_wdata = '0;
  logic ext_req = 1'b0;
  logic bus_req, m_valid, m_write, m_word, irq;
  logic bus_gnt = 1'b0;
  logic m_ready = 1'b0;
  logic [23:0] m_addr;
  logic [15:0] m_wdata, m_rdata;

  always #2.5 clk = ~clk;

  dma_autoreq_chan u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ext_req(ext_req), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .m_valid(m_valid), .m_ready(m_ready),
    .m_write(m_write), .m_word(m_word), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .irq(irq)
  );

  assign m_rdata = m_addr[15:0] ^ 16'h5A3C;

  int checks = 0, fails = 0;
  int units = 0, mon_err = 0, falls = 0, nogrant = 0;
  logic [23:0] exp_src = '0, exp_dst = '0;
  int stepv = 1;
  bit slow = 1'b0;
  logic prev_req = 1'b0;
  logic [7:0] lfsr = 8'hA7;

  // arbiter, memory ready and write monitor, all on the falling edge
  always @(negedge clk) begin
    logic nxt_rdy;
    logic [23:0] ea, es;
    nxt_rdy = slow ? lfsr[0] : 1'b1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (m_valid && !bus_gnt) nogrant++;
    if (m_valid && m_write && nxt_rdy) begin
      ea = exp_dst + 24'(units * stepv);
      es = exp_src + 24'(units * stepv);
      if (m_addr !== ea || m_wdata !== (es[15:0] ^ 16'h5A3C)) mon_err++;
      units++;
    end
    if (prev_req && !bus_req) falls++;
    prev_req = bus_req;
    bus_gnt <= bus_req;
    m_ready <= nxt_rdy;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [23:0] s, input logic [23:0] d,
                       input logic [15:0] n, input bit word);
    cfg_write(2'd0, s);
    cfg_write(2'd1, d);
    cfg_write(2'd2, {8'd0, n});
    exp_src = s; exp_dst = d; stepv = word ? 2 : 1;
    units = 0; mon_err = 0; falls = 0; nogrant = 0;
  endtask

  task automatic wait_irq(input int limit);
    for (int i = 0; i < limit && !irq; i++) @(negedge clk);
  endtask

  task automatic wait_units(input int n, input int limit);
    for (int i = 0; i < limit && units < n; i++) @(negedge clk);
  endtask

  // src, dst, count, word, burst, slow ready
  localparam logic [66:0] VEC [5] = '{
    {24'hC40010, 24'h1A2000, 16'd5, 1'b0, 1'b0, 1'b0},
    {24'h00FFF0, 24'h800100, 16'd4, 1'b1, 1'b0, 1'b1},
    {24'h3F0000, 24'h7F0002, 16'd6, 1'b1, 1'b1, 1'b0},
    {24'h1200FF, 24'h0A0001, 16'd7, 1'b0, 1'b1, 1'b1},
    {24'h123456, 24'hABCDEE, 16'd1, 1'b1, 1'b1, 1'b0}
  };

  initial begin
    int u1;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(bus_req == 1'b0 && m_valid == 1'b0 && irq == 1'b0, "R12", "idle outputs in reset",
          {bus_req, m_valid, irq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(bus_req == 1'b0 && irq == 1'b0, "R12", "idle after reset", {bus_req, irq}, 0);

    foreach (VEC[k]) begin
      logic [66:0] v;
      int n;
      v = VEC[k];
      n = int'(v[18:3]);
      slow = v[0];
      setup(v[66:43], v[42:19], v[18:3], v[2]);
      cfg_write(2'd3, {20'd0, v[2], v[1], 1'b1, 1'b1});
      wait_irq(2000);
      repeat (3) @(negedge clk);
      check(units == n, "R2", "units moved in auto mode", units, n);
      check(irq == 1'b1, "R7", "irq after full count", irq, 1);
      check(mon_err == 0, "R1", "addresses/data (R6 step, R10 back-pressure)", mon_err, 0);
      check(nogrant == 0, "R10", "access without grant", nogrant, 0);
      if (v[1]) check(falls == 1, "R4", "bus_req falls in burst", falls, 1);
      else      check(falls == n, "R3", "bus_req falls in cycle-steal", falls, n);
      cfg_write(2'd3, 24'd0);
      check(irq == 1'b0, "R7", "irq cleared by control write", irq, 0);
    end
    slow = 1'b0;

    // R5 external request mode
    setup(24'h450000, 24'h460000, 16'd3, 1'b0);
    cfg_write(2'd3, 24'h000001);
    repeat (20) @(negedge clk);
    check(units == 0, "R5", "no unit without request edge", units, 0);
    ext_req = 1'b1;
    repeat (25) @(negedge clk);
    check(units == 1, "R5", "one unit per edge, level held", units, 1);
    check(irq == 1'b0, "R5", "no irq before count", irq, 0);
    ext_req = 1'b0; @(negedge clk); ext_req = 1'b1; @(negedge clk); ext_req = 1'b0;
    repeat (20) @(negedge clk);
    check(units == 2, "R5", "second edge moves one unit", units, 2);
    ext_req = 1'b1; @(negedge clk); ext_req = 1'b0;
    repeat (20) @(negedge clk);
    check(units == 3 && irq == 1'b1, "R5", "third edge completes count", units, 3);
    check(mon_err == 0, "R6", "byte step in external mode", mon_err, 0);
    cfg_write(2'd3, 24'd0);

    // R8 stop mid-transfer
    setup(24'h010000, 24'h020000, 16'd50, 1'b0);
    cfg_write(2'd3, 24'h000003);
    wait_units(3, 500);
    cfg_write(2'd3, 24'd0);
    repeat (30) @(negedge clk);
    u1 = units;
    repeat (30) @(negedge clk);
    check(units == u1 && units < 6, "R8", "channel stopped", units, u1);
    check(bus_req == 1'b0 && irq == 1'b0, "R8", "bus released, no irq", {bus_req, irq}, 0);

    // R11 register writes while busy ignored
    setup(24'h600000, 24'h700000, 16'd4, 1'b1);
    cfg_write(2'd3, 24'h00000B);
    cfg_write(2'd0, 24'h0F0F0F);
    cfg_write(2'd1, 24'h0E0E0E);
    cfg_write(2'd2, 24'd9);
    cfg_write(2'd3, 24'h000007);
    wait_irq(2000);
    repeat (3) @(negedge clk);
    check(mon_err == 0, "R11", "addresses unchanged by busy writes", mon_err, 0);
    check(units == 4, "R11", "count unchanged by busy writes", units, 4);
    check(falls == 4, "R11", "mode bits unchanged by busy writes", falls, 4);
    cfg_write(2'd3, 24'd0);

    // R9 zero count means 65536
    setup(24'h200000, 24'h300000, 16'd0, 1'b1);
    cfg_write(2'd3, 24'h00000F);
    wait_units(300, 3000);
    check(units >= 300 && irq == 1'b0, "R9", "still running after 300 units", units, 300);
    check(bus_req == 1'b1, "R9", "bus held in burst", bus_req, 1);
    cfg_write(2'd3, 24'd0);
    repeat (10) @(negedge clk);
    check(irq == 1'b0 && bus_req == 1'b0, "R9", "stopped without irq", {irq, bus_req}, 0);
    check(mon_err == 0, "R6", "word step over long burst", mon_err, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule